// File: doc/BRIEF.md
# Radix-2^2 Odd-Stage Butterfly with Minus-j Rotator

This block is the odd-numbered half of one stage pair in a two-lane feedforward radix-2^2 FFT pipeline. On every clock where the input strobe is high it takes two complex fixed-point samples and forms their sum and their difference, each part saturated to the signed 32-bit range with 10 fraction bits (22 integer bits). The difference lane then passes a second register stage that can multiply it by -j. No multiplier is used: the real and imaginary parts swap places and the new imaginary part is negated.

The choice to rotate comes from one bit of the pair index counter that travels with the samples. Only the trivial quarter-turn happens here. Any remaining angle below a quarter turn belongs to the following even stage, so samples that need that finer rotation leave this block unchanged apart from the butterfly. The butterfly accepts a new pair on every valid cycle and so runs at full utilisation, with two samples in and two samples out per clock.

Top module: `r22_odd_stage`

## Requirements
- R1: While reset is asserted and after it is released with no valid input, `outValid` is 0 and all four output data words are 0.
- R2: For an input pair accepted with `inValid` high, `sumRe`/`sumIm` equal the saturated sums `aRe+bRe` and `aIm+bIm`, and they appear together with `outValid` exactly two clock edges after the input edge.
- R3: When index bit `inIdx[ROT_BIT]` is 0, `difRe`/`difIm` equal the saturated differences `aRe-bRe` and `aIm-bIm`.
- R4: When index bit `inIdx[ROT_BIT]` is 1, the difference is multiplied by -j: `difRe` equals the saturated `aIm-bIm` and `difIm` equals the negated saturated `aRe-bRe`.
- R5: Each sum and difference saturates to the range [-2^31, 2^31-1] instead of wrapping.
- R6: In the -j rotation, negating -2^31 gives 2^31-1.
- R7: `outValid` is `inValid` delayed by exactly two cycles, so back-to-back valid inputs give back-to-back valid outputs.
- R8: On cycles where `outValid` is 0 after a valid output, all four output data words keep their last values.
- R9: Index bits other than `inIdx[ROT_BIT]` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pair strobe |
| inIdx | input | IDX_W (3) | Pair index count; bit ROT_BIT (2) selects the -j rotation |
| aRe | input | DATA_W (32) | First sample, real part, signed Q22.10 |
| aIm | input | DATA_W (32) | First sample, imaginary part |
| bRe | input | DATA_W (32) | Second sample, real part |
| bIm | input | DATA_W (32) | Second sample, imaginary part |
| outValid | output | 1 | Output pair strobe |
| sumRe | output | DATA_W (32) | Butterfly sum, real part |
| sumIm | output | DATA_W (32) | Butterfly sum, imaginary part |
| difRe | output | DATA_W (32) | Difference after optional -j, real part |
| difIm | output | DATA_W (32) | Difference after optional -j, imaginary part |

## Verification
Difference saturation and rotation negation can happen on the same pair. The case is forced by a directed pair whose real difference clips to -2^31 while its index bit asks for rotation. The second clip then happens in the negation. The bench's model carries the clipped value into the swap and expects 2^31-1 on the imaginary output with the clipped imaginary difference on the real output. Random pairs with random index counts and idle gaps cover the other mixes.

// File: rtl/r22_pkg.sv
package r22_pkg;
  // Strobes handed from the control pipeline to the datapath
  typedef struct packed {
    logic bflyEn;  // load the butterfly register
    logic rotEn;   // load the rotator/output register
    logic rotSel;  // apply -j to the difference lane
  } stageCtl_t;
endpackage

// File: rtl/r22_ctl.sv
module r22_ctl
  import r22_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int ROT_BIT = IDX_W - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [IDX_W-1:0] inIdx,
  output stageCtl_t        ctl,
  output logic             outValid
);
  logic validQ1, validQ2, rotQ1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ1 <= 1'b0;
      validQ2 <= 1'b0;
      rotQ1   <= 1'b0;
    end else begin
      validQ1 <= inValid;
      validQ2 <= validQ1;
      if (inValid) rotQ1 <= inIdx[ROT_BIT];
    end
  end

  always_comb begin
    ctl.bflyEn = inValid;
    ctl.rotEn  = validQ1;
    ctl.rotSel = rotQ1;
  end
  assign outValid = validQ2;

  // R7
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);
endmodule

// File: rtl/r22_dp.sv
module r22_dp
  import r22_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stageCtl_t                ctl,
  input  logic signed [DATA_W-1:0] aRe,
  input  logic signed [DATA_W-1:0] aIm,
  input  logic signed [DATA_W-1:0] bRe,
  input  logic signed [DATA_W-1:0] bIm,
  output logic signed [DATA_W-1:0] sumRe,
  output logic signed [DATA_W-1:0] sumIm,
  output logic signed [DATA_W-1:0] difRe,
  output logic signed [DATA_W-1:0] difIm
);
  localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic signed [DATA_W-1:0] satAddSub(
    input logic signed [DATA_W-1:0] x,
    input logic signed [DATA_W-1:0] y,
    input logic                     sub);
    logic signed [DATA_W:0] w;
    w = sub ? ({x[DATA_W-1], x} - {y[DATA_W-1], y})
            : ({x[DATA_W-1], x} + {y[DATA_W-1], y});
    if (w[DATA_W] != w[DATA_W-1]) return w[DATA_W] ? MINV : MAXV;
    return w[DATA_W-1:0];
  endfunction

  function automatic logic signed [DATA_W-1:0] satNeg(
    input logic signed [DATA_W-1:0] x);
    return (x == MINV) ? MAXV : -x;
  endfunction

  // index 0 = real, 1 = imaginary
  logic signed [DATA_W-1:0] inA [2];
  logic signed [DATA_W-1:0] inB [2];
  logic signed [DATA_W-1:0] s1Sum [2];
  logic signed [DATA_W-1:0] s1Dif [2];

  always_comb begin
    inA[0] = aRe; inA[1] = aIm;
    inB[0] = bRe; inB[1] = bIm;
  end

  // Butterfly register stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        s1Sum[c] <= '0;
        s1Dif[c] <= '0;
      end
    end else if (ctl.bflyEn) begin
      for (int c = 0; c < 2; c++) begin
        s1Sum[c] <= satAddSub(inA[c], inB[c], 1'b0);
        s1Dif[c] <= satAddSub(inA[c], inB[c], 1'b1);
      end
    end
  end

  // Trivial rotator register stage: -j*(re + j im) = im - j re
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumRe <= '0; sumIm <= '0; difRe <= '0; difIm <= '0;
    end else if (ctl.rotEn) begin
      sumRe <= s1Sum[0];
      sumIm <= s1Sum[1];
      if (ctl.rotSel) begin
        difRe <= s1Dif[1];
        difIm <= satNeg(s1Dif[0]);
      end else begin
        difRe <= s1Dif[0];
        difIm <= s1Dif[1];
      end
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.bflyEn && !aRe[DATA_W-1] && !bRe[DATA_W-1]) |=> !s1Sum[0][DATA_W-1]);
  // R4
  rot_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rotEn && ctl.rotSel) |=> (difRe == $past(s1Dif[1])));
  // R6
  neg_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rotEn && ctl.rotSel && s1Dif[0] == MINV) |=> (difIm == MAXV));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rotEn |=> ($stable(sumRe) && $stable(sumIm) && $stable(difRe) && $stable(difIm)));
endmodule

// File: rtl/r22_odd_stage.sv
module r22_odd_stage
  import r22_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3,
  parameter int ROT_BIT = IDX_W - 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [IDX_W-1:0]         inIdx,
  input  logic signed [DATA_W-1:0] aRe,
  input  logic signed [DATA_W-1:0] aIm,
  input  logic signed [DATA_W-1:0] bRe,
  input  logic signed [DATA_W-1:0] bIm,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] sumRe,
  output logic signed [DATA_W-1:0] sumIm,
  output logic signed [DATA_W-1:0] difRe,
  output logic signed [DATA_W-1:0] difIm
);
  stageCtl_t ctl;

  r22_ctl #(.IDX_W(IDX_W), .ROT_BIT(ROT_BIT)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIdx(inIdx),
    .ctl(ctl), .outValid(outValid));

  r22_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .sumRe(sumRe), .sumIm(sumIm), .difRe(difRe), .difIm(difIm));
endmodule

// File: tb/r22_odd_stage_tb.sv
module r22_odd_stage_tb;
  localparam int W = 32;
  localparam logic signed [W-1:0] MAXV = 32'sh7fffffff;
  localparam logic signed [W-1:0] MINV = 32'sh80000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] inIdx = '0;
  logic signed [W-1:0] aRe = '0, aIm = '0, bRe = '0, bIm = '0;
  logic outValid;
  logic signed [W-1:0] sumRe, sumIm, difRe, difIm;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  r22_odd_stage u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIdx(inIdx),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .outValid(outValid), .sumRe(sumRe), .sumIm(sumIm),
    .difRe(difRe), .difIm(difIm));

  // expected pipeline: p0 driven last negedge, p1 two negedges ago
  logic p0v = 1'b0, p1v = 1'b0;
  logic signed [W-1:0] p0[4], p1[4], hold[4];
  string p0t = "", p1t = "";

  function automatic logic signed [W-1:0] sat(input longint v);
    if (v > 64'sd2147483647) return MAXV;
    if (v < -64'sd2147483648) return MINV;
    return v[W-1:0];
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] idx,
                      input logic signed [W-1:0] ar, input logic signed [W-1:0] ai,
                      input logic signed [W-1:0] br, input logic signed [W-1:0] bi,
                      input string tag);
    logic signed [W-1:0] dr, di;
    @(negedge clk);
    if (p1v) begin
      chk("R7", "outValid", longint'(outValid), 1);
      chk(p1t, "sumRe", sumRe, p1[0]);
      chk(p1t, "sumIm", sumIm, p1[1]);
      chk(p1t, "difRe", difRe, p1[2]);
      chk(p1t, "difIm", difIm, p1[3]);
      for (int k = 0; k < 4; k++) hold[k] = p1[k];
    end else begin
      chk("R7", "outValid", longint'(outValid), 0);
      chk("R8", "difRe hold", difRe, hold[2]);
      chk("R8", "sumIm hold", sumIm, hold[1]);
    end
    p1v = p0v; p1t = p0t;
    for (int k = 0; k < 4; k++) p1[k] = p0[k];
    dr = sat(longint'(ar) - longint'(br));
    di = sat(longint'(ai) - longint'(bi));
    p0v = v;
    p0[0] = sat(longint'(ar) + longint'(br));
    p0[1] = sat(longint'(ai) + longint'(bi));
    if (idx[2]) begin
      p0[2] = di;
      p0[3] = (dr == MINV) ? MAXV : -dr;
      p0t = (tag != "") ? tag : "R4";
    end else begin
      p0[2] = dr;
      p0[3] = di;
      p0t = (tag != "") ? tag : "R3";
    end
    inValid = v; inIdx = idx; aRe = ar; aIm = ai; bRe = br; bIm = bi;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) begin p0[k] = '0; p1[k] = '0; hold[k] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "outValid", longint'(outValid), 0);
    chk("R1", "sumRe", sumRe, 0);
    chk("R1", "difIm", difIm, 0);
    rstN = 1'b1;
    step(1'b0, 3'd0, 0, 0, 0, 0, "R1");
    step(1'b0, 3'd0, 0, 0, 0, 0, "R1");
    // directed: plain add/sub (R2, R3), rotation (R4)
    step(1'b1, 3'd0, 32'sd1000, -32'sd2048, 32'sd300, 32'sd48, "R2");
    step(1'b1, 3'd4, 32'sd1000, -32'sd2048, 32'sd300, 32'sd48, "R4");
    // R5 saturation on sums and differences
    step(1'b1, 3'd1, MAXV, MINV, 32'sd5, -32'sd5, "R5");
    step(1'b1, 3'd2, MINV, MAXV, MAXV, MINV, "R5");
    // R6 rotation with real difference clipped to MIN
    step(1'b1, 3'd4, MINV, MAXV, 32'sd7, MINV, "R6");
    step(1'b1, 3'd7, MINV, 32'sd0, 32'sd0, 32'sd0, "R6");
    // R9 other index bits do not matter
    step(1'b1, 3'd3, 32'sd77, 32'sd11, -32'sd9, 32'sd4, "R9");
    step(1'b1, 3'd5, 32'sd77, 32'sd11, -32'sd9, 32'sd4, "R9");
    // R8 idle gap with garbage inputs
    step(1'b0, 3'd4, MAXV, MAXV, MINV, MINV, "R8");
    step(1'b0, 3'd0, 32'sd1, 32'sd2, 32'sd3, 32'sd4, "R8");
    step(1'b0, 3'd0, 32'sd1, 32'sd2, 32'sd3, 32'sd4, "R8");
    // random mix, back-to-back and gaps (R7)
    for (int i = 0; i < 400; i++) begin
      logic signed [W-1:0] r0, r1, r2, r3;
      r0 = $urandom; r1 = $urandom; r2 = $urandom; r3 = $urandom;
      if ($urandom % 4 == 0) begin r0 = r0 >>> 12; r2 = r2 >>> 12; end
      step(($urandom % 5) != 0, 3'($urandom), r0, r1, r2, r3, "");
    end
    step(1'b0, 3'd0, 0, 0, 0, 0, "R8");
    step(1'b0, 3'd0, 0, 0, 0, 0, "R8");
    step(1'b0, 3'd0, 0, 0, 0, 0, "R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule